// File: doc/BRIEF.md
# Serial SAR Converter Read Controller

This block is the host side of a three-wire link to a 12-bit successive-approximation converter. A start request pulls the active-low select line down, which makes the converter take its sample and begin converting. After a short setup gap the controller emits exactly sixteen serial clock pulses. It samples the converter's data line on every rising clock edge, since the converter moves its data line on falling edges. The sixteen bits arrive most significant first: four header bits that must read zero, then the twelve result bits.

When the sixteenth pulse has finished, select goes high again. In the same cycle the twelve result bits appear as a signed two's-complement value with a one-cycle valid strobe. A separate one-cycle flag reports a nonzero header. A quiet gap counted in system clock cycles separates one frame from the next. The serial clock half-period is given in system cycles on an input and is taken in at the start of each frame. Requests that arrive while a frame or the quiet gap is running are held and served later.

Top module: `sar_adc_reader`

## Requirements
- R1: With the controller idle, a start request sampled on a clock edge drives `adc_cs_n` low on that same edge.
- R2: `adc_sclk` is low whenever `adc_cs_n` is high and during the setup gap. `adc_cs_n` stays low for exactly SETUP_CYC cycles before the first serial clock rising edge.
- R3: Every frame holds exactly 16 serial clock pulses. Each pulse is high for H cycles and then low for H cycles. H is the value of `sclk_half` taken in when the frame starts, and a value of 0 is used as 1.
- R4: The data line is sampled at each serial clock rising edge, 16 samples in all. The first four samples form the header. The last twelve form `sample_data` bits 11 down to 0, in that order.
- R5: `sample_valid` is a one-cycle pulse on the same edge where `adc_cs_n` returns high, which is SETUP_CYC + 32·H cycles after select fell. `sample_data` is the two's-complement reading of the twelve result bits and holds until the next pulse.
- R6: `lead_err` pulses together with `sample_valid` if any header bit was 1, and the sample is still delivered.
- R7: Between frames `adc_cs_n` stays high for QUIET_CYC + 1 cycles at minimum.
- R8: A start request that arrives during a frame or the quiet gap is remembered and starts one further frame once the controller is idle. Several such requests before that start merge into one.
- R9: While `rst` is high: `adc_cs_n` = 1, `adc_sclk` = 0, `sample_valid` = 0, `lead_err` = 0 and `sample_data` = 0.
- R10: A change on `sclk_half` during a frame does not alter the timing of that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Request for one conversion frame |
| sclk_half | input | DIV_W | Serial clock half-period in system cycles (0 is used as 1) |
| adc_sdata | input | 1 | Serial data from the converter |
| adc_cs_n | output | 1 | Active-low select; its falling edge starts a conversion |
| adc_sclk | output | 1 | Serial clock to the converter, idles low |
| sample_data | output | 12 | Signed result of the last frame |
| sample_valid | output | 1 | One-cycle strobe for a new result |
| lead_err | output | 1 | One-cycle flag for a nonzero header |

## Verification
Select falls on the edge that samples the request, so it can be seen one half-period later. The first serial rising edge comes SETUP_CYC cycles after select falls. The valid strobe, the header flag and the new sample all appear SETUP_CYC + 32·H cycles after the falling edge of select, and select rises on that same edge. The bench holds a behavioural model that counts cycles from the frame start by these formulas. It updates the model on each rising edge and compares select, serial clock, strobe, flag and sample on the following falling edge, so every expected value is due at the exact cycle given above. A converter model in the bench moves its data line one nanosecond after each serial falling edge, and the results are checked against the words it sent.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;
    localparam int FRAME_LEN = 16;
    localparam int LEAD_LEN  = 4;
    localparam int WORD_W    = FRAME_LEN - LEAD_LEN;
    localparam int BIT_W     = $clog2(FRAME_LEN);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT,
        ST_QUIET
    } seq_st_e;

    typedef struct packed {
        logic [WORD_W-1:0] value;
        logic              lead_bad;
    } frame_res_t;

    function automatic frame_res_t split_frame(input logic [FRAME_LEN-1:0] w);
        frame_res_t r;
        r.value    = w[WORD_W-1:0];
        r.lead_bad = |w[FRAME_LEN-1 -: LEAD_LEN];
        return r;
    endfunction
endpackage

// File: rtl/sar_rd_req.sv
module sar_rd_req (
    input  logic clk,
    input  logic rst,
    input  logic start_req,
    input  logic idle,
    output logic go
);
    logic pend_q;

    assign go = idle & (pend_q | start_req);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= (pend_q | start_req) & ~go;
        end
    end
endmodule

// File: rtl/sar_rd_seq.sv
module sar_rd_seq
    import sar_rd_pkg::*;
#(
    parameter int SETUP_CYC = 3,
    parameter int QUIET_CYC = 15,
    parameter int DIV_W     = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [DIV_W-1:0] half_in,
    output logic             idle,
    output logic             cs_n,
    output logic             sclk,
    output logic             cap,
    output logic             done
);
    localparam int TMR_MAX = (SETUP_CYC > QUIET_CYC) ? SETUP_CYC : QUIET_CYC;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam int PH_W    = DIV_W + 1;

    seq_st_e            st_q, st_n;
    logic [TMR_W-1:0]   tmr_q, tmr_n;
    logic [PH_W-1:0]    ph_q, ph_n;
    logic [BIT_W-1:0]   bit_q, bit_n;
    logic [DIV_W-1:0]   half_q, half_n, half_eff;
    logic               cs_q, sclk_q, sclk_n;

    assign half_eff = (half_in == '0) ? DIV_W'(1) : half_in;

    always_comb begin
        st_n   = st_q;
        tmr_n  = tmr_q;
        ph_n   = ph_q;
        bit_n  = bit_q;
        half_n = half_q;
        done   = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (go) begin
                    st_n   = ST_SETUP;
                    tmr_n  = '0;
                    half_n = half_eff;
                end
            end
            ST_SETUP: begin
                if (tmr_q == TMR_W'(SETUP_CYC - 1)) begin
                    st_n  = ST_SHIFT;
                    ph_n  = '0;
                    bit_n = '0;
                end else begin
                    tmr_n = tmr_q + TMR_W'(1);
                end
            end
            ST_SHIFT: begin
                if (ph_q == ({half_q, 1'b0} - PH_W'(1))) begin
                    ph_n = '0;
                    if (bit_q == BIT_W'(FRAME_LEN - 1)) begin
                        st_n  = ST_QUIET;
                        tmr_n = '0;
                        done  = 1'b1;
                    end else begin
                        bit_n = bit_q + BIT_W'(1);
                    end
                end else begin
                    ph_n = ph_q + PH_W'(1);
                end
            end
            default: begin
                if (tmr_q == TMR_W'(QUIET_CYC - 1)) begin
                    st_n = ST_IDLE;
                end else begin
                    tmr_n = tmr_q + TMR_W'(1);
                end
            end
        endcase
    end

    assign sclk_n = (st_n == ST_SHIFT) && (ph_n < {1'b0, half_n});
    assign cap    = sclk_n & ~sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            tmr_q  <= '0;
            ph_q   <= '0;
            bit_q  <= '0;
            half_q <= DIV_W'(1);
            cs_q   <= 1'b1;
            sclk_q <= 1'b0;
        end else begin
            st_q   <= st_n;
            tmr_q  <= tmr_n;
            ph_q   <= ph_n;
            bit_q  <= bit_n;
            half_q <= half_n;
            cs_q   <= !((st_n == ST_SETUP) || (st_n == ST_SHIFT));
            sclk_q <= sclk_n;
        end
    end

    assign idle = (st_q == ST_IDLE);
    assign cs_n = cs_q;
    assign sclk = sclk_q;
endmodule

// File: rtl/sar_rd_capture.sv
module sar_rd_capture
    import sar_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap,
    input  logic              done,
    input  logic              sdata,
    output logic [WORD_W-1:0] sample,
    output logic              valid,
    output logic              err
);
    logic [FRAME_LEN-1:0] shift_q;
    frame_res_t           res;

    assign res = split_frame(shift_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            sample  <= '0;
            valid   <= 1'b0;
            err     <= 1'b0;
        end else begin
            if (cap) begin
                shift_q <= {shift_q[FRAME_LEN-2:0], sdata};
            end
            valid <= done;
            err   <= done & res.lead_bad;
            if (done) begin
                sample <= res.value;
            end
        end
    end
endmodule

// File: rtl/sar_adc_reader.sv
module sar_adc_reader
    import sar_rd_pkg::*;
#(
    parameter int SETUP_CYC = 3,
    parameter int QUIET_CYC = 15,
    parameter int DIV_W     = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start_req,
    input  logic [DIV_W-1:0]         sclk_half,
    input  logic                     adc_sdata,
    output logic                     adc_cs_n,
    output logic                     adc_sclk,
    output logic signed [WORD_W-1:0] sample_data,
    output logic                     sample_valid,
    output logic                     lead_err
);
    logic              idle, go, cap, done;
    logic [WORD_W-1:0] sample_raw;

    sar_rd_req u_req (
        .clk       (clk),
        .rst       (rst),
        .start_req (start_req),
        .idle      (idle),
        .go        (go)
    );

    sar_rd_seq #(
        .SETUP_CYC (SETUP_CYC),
        .QUIET_CYC (QUIET_CYC),
        .DIV_W     (DIV_W)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .half_in (sclk_half),
        .idle    (idle),
        .cs_n    (adc_cs_n),
        .sclk    (adc_sclk),
        .cap     (cap),
        .done    (done)
    );

    sar_rd_capture u_cap (
        .clk    (clk),
        .rst    (rst),
        .cap    (cap),
        .done   (done),
        .sdata  (adc_sdata),
        .sample (sample_raw),
        .valid  (sample_valid),
        .err    (lead_err)
    );

    assign sample_data = signed'(sample_raw);
endmodule

// File: rtl/sar_adc_reader_chk.sv
module sar_adc_reader_chk #(
    parameter int QUIET_CYC = 15
) (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic sclk,
    input logic valid,
    input logic err
);
    localparam int HW = $clog2(QUIET_CYC + 2) + 1;

    logic          sclk_d;
    logic [4:0]    rise_cnt;
    logic [HW-1:0] high_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d   <= 1'b0;
            rise_cnt <= '0;
            high_cnt <= HW'(QUIET_CYC + 1);
        end else begin
            sclk_d <= sclk;
            if (sclk && !sclk_d) begin
                rise_cnt <= rise_cnt + 5'd1;
            end else if (cs_n) begin
                rise_cnt <= '0;
            end
            if (!cs_n) begin
                high_cnt <= '0;
            end else if (high_cnt < HW'(QUIET_CYC + 1)) begin
                high_cnt <= high_cnt + HW'(1);
            end
        end
    end

    // R2
    sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
        sclk |-> !cs_n);

    // R2
    cs_fall_low_clk_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> !sclk);

    // R3
    pulse_count_chk: assert property (@(posedge clk) disable iff (rst)
        valid |-> (rise_cnt == 5'd16));

    // R5
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    // R5
    valid_at_cs_rise_chk: assert property (@(posedge clk) disable iff (rst)
        valid |-> (cs_n && !$past(cs_n)));

    // R6
    err_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> valid);

    // R7
    quiet_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> (high_cnt >= HW'(QUIET_CYC + 1)));
endmodule

bind sar_adc_reader sar_adc_reader_chk #(.QUIET_CYC(QUIET_CYC)) i_chk (
    .clk   (clk),
    .rst   (rst),
    .cs_n  (adc_cs_n),
    .sclk  (adc_sclk),
    .valid (sample_valid),
    .err   (lead_err)
);

// File: tb/test_sar_adc_reader.sv
module test_sar_adc_reader;
    localparam int S = 3;
    localparam int Q = 15;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_req = 1'b0;
    logic [7:0] half = 8'd2;
    logic sdata = 1'b0;
    logic adc_cs_n, adc_sclk, sample_valid, lead_err;
    logic signed [11:0] sample_data;

    int checks = 0;
    int errors = 0;
    int n_valid = 0;

    always #2 clk = ~clk;

    sar_adc_reader i_sar_adc_reader (
        .clk          (clk),
        .rst          (rst),
        .start_req    (start_req),
        .sclk_half    (half),
        .adc_sdata    (sdata),
        .adc_cs_n     (adc_cs_n),
        .adc_sclk     (adc_sclk),
        .sample_data  (sample_data),
        .sample_valid (sample_valid),
        .lead_err     (lead_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // converter model: header and data shifted out MSB first
    logic [15:0] adc_words[$];
    logic [15:0] sent_q[$];
    logic [15:0] cur_word = 16'h0;
    int adc_idx = 0;

    always @(negedge adc_cs_n) begin
        if (adc_words.size() > 0) cur_word = adc_words.pop_front();
        else cur_word = 16'h0;
        sent_q.push_back(cur_word);
        adc_idx = 0;
        #1 sdata = cur_word[15];
    end

    always @(negedge adc_sclk) begin
        adc_idx++;
        #1 sdata = (adc_idx < 16) ? cur_word[15 - adc_idx] : 1'b0;
    end

    // behavioural reference: cycle count since frame start
    int m_mode = 0;
    int m_t = 0;
    int m_q = 0;
    int m_h = 1;
    bit m_pend = 1'b0;
    bit exp_cs = 1'b1;
    bit exp_sclk = 1'b0;
    bit exp_valid = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_pend = 1'b0;
            exp_cs = 1'b1; exp_sclk = 1'b0; exp_valid = 1'b0;
        end else begin
            exp_valid = 1'b0;
            if (m_mode == 0) begin
                if (m_pend || start_req) begin
                    m_mode = 1; m_t = 0; m_pend = 1'b0;
                    m_h = (half == 0) ? 1 : int'(half);
                end
            end else if (m_mode == 1) begin
                m_pend = m_pend | start_req;
                m_t++;
                if (m_t == S + 32 * m_h) begin
                    m_mode = 2; m_q = 0; exp_valid = 1'b1;
                end
            end else begin
                m_pend = m_pend | start_req;
                m_q++;
                if (m_q == Q) m_mode = 0;
            end
            exp_cs = (m_mode != 1);
            exp_sclk = (m_mode == 1) && (m_t >= S) && (((m_t - S) % (2 * m_h)) < m_h);
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            check(adc_cs_n == exp_cs, "R1 R2 R7 R8", "cs_n", adc_cs_n, exp_cs);
            check(adc_sclk == exp_sclk, "R3 R10", "sclk", adc_sclk, exp_sclk);
            check(sample_valid == exp_valid, "R5", "valid", sample_valid, exp_valid);
            if (exp_valid) begin
                logic [15:0] w;
                n_valid++;
                w = (sent_q.size() > 0) ? sent_q.pop_front() : 16'h0;
                check(int'(sample_data) == int'($signed(w[11:0])), "R4 R5", "sample",
                      int'(sample_data), int'($signed(w[11:0])));
                check(lead_err == (|w[15:12]), "R6", "lead_err", lead_err, int'(|w[15:12]));
            end else begin
                check(lead_err == 1'b0, "R6", "lead_err idle", lead_err, 0);
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start();
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
    endtask

    initial begin
        adc_words.push_back(16'h0123);
        adc_words.push_back(16'h0800);
        adc_words.push_back(16'h07FF);
        adc_words.push_back(16'h0FFF);
        adc_words.push_back(16'h5A5A);
        adc_words.push_back(16'h8000);
        adc_words.push_back(16'h0001);

        wait_cyc(5);
        // R9 reset values
        check(adc_cs_n == 1'b1, "R9", "reset cs_n", adc_cs_n, 1);
        check(adc_sclk == 1'b0, "R9", "reset sclk", adc_sclk, 0);
        check(sample_valid == 1'b0, "R9", "reset valid", sample_valid, 0);
        check(lead_err == 1'b0, "R9", "reset err", lead_err, 0);
        check(sample_data == 12'sd0, "R9", "reset sample", int'(sample_data), 0);
        rst = 1'b0;
        wait_cyc(3);

        // single frame, H=2
        half = 8'd2;
        pulse_start();
        wait_cyc(S + 64 + Q + 5);

        // request held three cycles: one frame plus one pending (R8)
        half = 8'd1;
        start_req = 1'b1;
        wait_cyc(3);
        start_req = 1'b0;
        wait_cyc(2 * (S + 32 + Q + 2) + 5);
        check(n_valid == 3, "R8", "frames after held request", n_valid, 3);

        // request during frame is served after quiet gap (R8)
        half = 8'd2;
        pulse_start();
        wait_cyc(30);
        pulse_start();
        wait_cyc(2 * (S + 64 + Q + 2) + 5);
        check(n_valid == 5, "R8", "frames after mid-frame request", n_valid, 5);

        // divider changed mid frame has no effect (R10)
        half = 8'd3;
        pulse_start();
        wait_cyc(20);
        half = 8'd1;
        wait_cyc(S + 96 + Q + 5);

        // zero divider used as one (R3)
        half = 8'd0;
        pulse_start();
        wait_cyc(S + 32 + Q + 5);

        check(n_valid == 7, "R8", "total frames", n_valid, 7);
        check(sent_q.size() == 0, "R4", "unread words", sent_q.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        checks++;
        errors++;
        $display("FAIL R8 watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule